// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one raw level vector. It drives two processor request lines from that vector. The normal request line is asserted while any raw bit is also set in the normal enable mask. The fast request line is asserted in the same way through a second, independent enable mask. Each enable mask is changed through a pair of write addresses: one ORs the written ones into the mask, and the other clears the bits where the written value has ones. Both request lines are registered, so each follows the state of the previous cycle.

Source 0 can also be raised by software. A private latch is set and cleared through two more write addresses, and the latch is ORed with external line 0. A software write therefore cannot hide the hardware line, and the hardware line cannot drop a software request. For each channel, software can read the masked status, the raw vector and the enable mask. To cascade two controllers, the normal request output of the secondary instance is wired to source 26 of the primary instance.

Top module: `intc_dual`

## Requirements
- R1: After a synchronous active-low reset, both enable masks are zero, the software latch is clear, and irq_o and fiq_o are low.
- R2: At each clock edge, irq_o takes the value (raw AND normal mask) != 0 sampled before that edge. A change of an input line or of the mask therefore shows on irq_o one cycle later.
- R3: At each clock edge, fiq_o takes the value (raw AND fast mask) != 0 sampled before that edge, independently of the normal mask.
- R4: A write to word 2 ORs the data into the normal mask, and a write to word 3 clears the mask bits where the data is 1. A read of word 2 returns the normal mask.
- R5: A write to word 10 ORs the data into the fast mask, and a write to word 11 clears the mask bits where the data is 1. A read of word 10 returns the fast mask.
- R6: A read of word 0 returns raw AND normal mask, and a read of word 8 returns raw AND fast mask. A read of word 1 or word 9 returns the raw vector. Reads are combinational in the same cycle.
- R7: A write to word 4 with data bit 0 set sets the software latch. A write to word 5 with data bit 0 set clears it. Writes with data bit 0 clear have no effect. A read of word 4 returns raw bit 0 in bit 0 and zeros elsewhere.
- R8: Raw bit 0 is the OR of external line 0 and the software latch. Every other raw bit equals its input line.
- R9: Reads of the write-only words 3, 5 and 11, and of the unused words 6, 7 and 12 to 15, return zero.
- R10: Writes to the status words 0, 1, 8 and 9 change neither mask, nor the latch, nor either output.
- R11: When a secondary instance's irq_o drives source 26 of a primary instance, the primary irq_o rises two cycles after the secondary source rises, provided both are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Word address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for bus_addr, combinational |
| src_i | input | N_SRC (32) | Level-sensitive interrupt lines |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The sources are driven with a two-bit pattern in which only one bit is enabled on each channel. This shows that each channel uses its own mask and that the masked reads differ from the raw reads. The mask checks set high and low bits in separate writes, which separates an OR update from an overwrite, and then clear a subset, which separates a selective clear from a full clear. On source 0, the software latch and external line 0 are toggled in overlapping and non-overlapping orders, which shows that the two are ORed and that data bits other than bit 0 are ignored. A two-instance cascade then measures the two-cycle latency through the chained registered outputs.

// File: rtl/intc_pkg.sv
// Package: shared word indices and widths for the dual-output interrupt
// controller. Assumes a word-addressed bus in which the fast channel's
// words sit 8 above the normal channel's words.
package intc_pkg;
    localparam int unsigned CH_COUNT   = 2;   // normal and fast channel
    localparam int unsigned CH_STRIDE  = 8;   // word distance between channels
    localparam int unsigned OFS_STAT   = 0;   // masked status, read only
    localparam int unsigned OFS_RAW    = 1;   // raw vector, read only
    localparam int unsigned OFS_ENSET  = 2;   // mask OR-write / mask read
    localparam int unsigned OFS_ENCLR  = 3;   // mask clear-write
    localparam int unsigned WORD_SWSET = 4;   // software latch set / raw bit 0 read
    localparam int unsigned WORD_SWCLR = 5;   // software latch clear

    // Word index of a channel register.
    function automatic int unsigned ch_word(int unsigned ch, int unsigned ofs);
        return ch * CH_STRIDE + ofs;
    endfunction
endpackage

// File: rtl/intc_src.sv
// Module: raw level vector builder. Passes every input line straight
// through and ORs a software latch into bit 0. Assumes the set and clear
// strobes are never high together (one bus write per cycle).
module intc_src #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_set,
    input  logic             sw_clr,
    input  logic [N_SRC-1:0] lines_i,
    output logic [N_SRC-1:0] raw_o
);
    logic sw_q;

    // Software latch for source 0, set and cleared by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      sw_q <= 1'b0;
        else if (sw_set) sw_q <= 1'b1;
        else if (sw_clr) sw_q <= 1'b0;
    end

    // Raw vector: line levels, with bit 0 also held by the latch.
    always_comb begin
        raw_o    = lines_i;
        raw_o[0] = lines_i[0] | sw_q;
    end

    // R7
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set |=> raw_o[0]);
    // R8
    sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (raw_o[0] == lines_i[0]));
endmodule

// File: rtl/intc_mask.sv
// Module: one output channel. Holds an enable mask updated by OR-set and
// AND-NOT-clear writes, forms the masked vector and registers the OR of
// it as the request line. Assumes set and clear are never high together.
module intc_mask #(
    parameter int unsigned N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [N_SRC-1:0] wdata,
    input  logic [N_SRC-1:0] raw,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] masked,
    output logic             line_q
);
    // Enable mask update from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (en_set) en_q <= en_q | wdata;
        else if (en_clr) en_q <= en_q & ~wdata;
    end

    // Masked status for reads and for the request line.
    assign masked = raw & en_q;

    // Registered request line, one cycle behind the masked vector.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= |masked;
    end

    // R4 / R5: every written one is set afterwards
    set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> ((en_q & $past(wdata)) == $past(wdata)));
    // R4 / R5: every written one is cleared afterwards
    clr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> ((en_q & $past(wdata)) == '0));
    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_set && !en_clr) |=> $stable(en_q));
    // R2 / R3
    line_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_q) |-> $past(raw & en_q) != '0);
    // R2 / R3
    line_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_q) |-> $past(raw & en_q) == '0);
endmodule

// File: rtl/intc_rdmux.sv
// Module: read data selection. Purely combinational. Assumes N_SRC is no
// wider than the bus; unused and write-only words read as zero.
module intc_rdmux
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SRC-1:0]  raw,
    input  logic [N_SRC-1:0]  en_irq,
    input  logic [N_SRC-1:0]  en_fiq,
    input  logic [N_SRC-1:0]  msk_irq,
    input  logic [N_SRC-1:0]  msk_fiq,
    output logic [BUS_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] A_ISTAT = ADDR_W'(ch_word(0, OFS_STAT));
    localparam logic [ADDR_W-1:0] A_IRAW  = ADDR_W'(ch_word(0, OFS_RAW));
    localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(ch_word(0, OFS_ENSET));
    localparam logic [ADDR_W-1:0] A_FSTAT = ADDR_W'(ch_word(1, OFS_STAT));
    localparam logic [ADDR_W-1:0] A_FRAW  = ADDR_W'(ch_word(1, OFS_RAW));
    localparam logic [ADDR_W-1:0] A_FEN   = ADDR_W'(ch_word(1, OFS_ENSET));
    localparam logic [ADDR_W-1:0] A_SW    = ADDR_W'(WORD_SWSET);

    // Select the addressed view and zero-extend it to the bus.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_ISTAT:        rdata[N_SRC-1:0] = msk_irq;
            A_IRAW, A_FRAW: rdata[N_SRC-1:0] = raw;
            A_IEN:          rdata[N_SRC-1:0] = en_irq;
            A_FSTAT:        rdata[N_SRC-1:0] = msk_fiq;
            A_FEN:          rdata[N_SRC-1:0] = en_fiq;
            A_SW:           rdata[0]         = raw[0];
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_dual.sv
// Module: top of the dual-output level interrupt controller. Decodes bus
// writes into strobes, builds the raw vector and runs one mask channel
// per output. Assumes one bus access per cycle and N_SRC <= BUS_W.
module intc_dual
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC  = 32,
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  src_i,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam logic [ADDR_W-1:0] A_SWSET = ADDR_W'(WORD_SWSET);
    localparam logic [ADDR_W-1:0] A_SWCLR = ADDR_W'(WORD_SWCLR);

    logic [N_SRC-1:0] raw;
    logic [N_SRC-1:0] en_v  [CH_COUNT];
    logic [N_SRC-1:0] msk_v [CH_COUNT];
    logic             line_v[CH_COUNT];
    logic             sw_set, sw_clr;

    // Software latch strobes: only data bit 0 acts.
    assign sw_set = bus_wr && (bus_addr == A_SWSET) && bus_wdata[0];
    assign sw_clr = bus_wr && (bus_addr == A_SWCLR) && bus_wdata[0];

    intc_src #(.N_SRC(N_SRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_set  (sw_set),
        .sw_clr  (sw_clr),
        .lines_i (src_i),
        .raw_o   (raw)
    );

    // One mask channel per output; channel k answers at words 8k+2 / 8k+3.
    for (genvar k = 0; k < CH_COUNT; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(ch_word(k, OFS_ENSET));
        localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(ch_word(k, OFS_ENCLR));
        logic set_stb, clr_stb;

        // Write strobes for this channel's mask.
        assign set_stb = bus_wr && (bus_addr == A_SET);
        assign clr_stb = bus_wr && (bus_addr == A_CLR);

        intc_mask #(.N_SRC(N_SRC)) u_mask (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_set (set_stb),
            .en_clr (clr_stb),
            .wdata  (bus_wdata[N_SRC-1:0]),
            .raw    (raw),
            .en_q   (en_v[k]),
            .masked (msk_v[k]),
            .line_q (line_v[k])
        );
    end

    assign irq_o = line_v[0];
    assign fiq_o = line_v[1];

    intc_rdmux #(.N_SRC(N_SRC), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rd (
        .addr    (bus_addr),
        .raw     (raw),
        .en_irq  (en_v[0]),
        .en_fiq  (en_v[1]),
        .msk_irq (msk_v[0]),
        .msk_fiq (msk_v[1]),
        .rdata   (bus_rdata)
    );

    // R1: outputs are low in the first cycle after reset
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fiq_o));
    // R8: lines above bit 0 pass unchanged into the raw vector
    raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[N_SRC-1:1] == src_i[N_SRC-1:1]));
endmodule

// File: tb/intc_dual_tb.sv
`timescale 1ns/1ps
module intc_dual_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src_ext = '0;
    logic        irq, fiq;
    logic [3:0]  s_addr = '0;
    logic        s_wr = 1'b0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata;
    logic [31:0] s_src = '0;
    logic        s_irq, s_fiq;
    logic [31:0] dut_src;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    // Primary takes the secondary's normal request on source 26 (R11).
    always_comb begin
        dut_src     = src_ext;
        dut_src[26] = s_irq;
    end

    intc_dual u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .src_i(dut_src),
        .irq_o(irq), .fiq_o(fiq)
    );

    intc_dual u_sec (
        .clk(clk), .rst_n(rst_n), .bus_addr(s_addr), .bus_wr(s_wr),
        .bus_wdata(s_wdata), .bus_rdata(s_rdata), .src_i(s_src),
        .irq_o(s_irq), .fiq_o(s_fiq)
    );

    // Monitor: after each rising edge, pop and compare queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_pin ? {30'd0, irq, fiq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic sec_write(input logic [3:0] a, input logic [31:0] d);
        s_addr = a; s_wdata = d; s_wr = 1'b1;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic exp_pins(input logic i, input logic f, input string tag);
        item_t it;
        it.is_pin = 1'b1; it.exp = {30'd0, i, f}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        exp_pins(1'b0, 1'b0, "R1 pins");
        exp_rd(4'd2, 32'h0, "R1 irq mask");
        exp_rd(4'd10, 32'h0, "R1 fiq mask");
        exp_rd(4'd4, 32'h0, "R1 sw latch");
        // R6 / R2 raw view with nothing enabled
        src_ext = 32'h0000_0030;
        exp_rd(4'd1, 32'h30, "R6 raw");
        exp_pins(1'b0, 1'b0, "R2 masked off");
        // R4 / R2 normal channel
        bus_write(4'd2, 32'h10);
        exp_rd(4'd2, 32'h10, "R4 mask set");
        exp_pins(1'b1, 1'b0, "R2 irq on");
        exp_rd(4'd0, 32'h10, "R6 irq status");
        exp_rd(4'd8, 32'h0, "R6 fiq status");
        // R5 / R3 fast channel
        bus_write(4'd10, 32'h20);
        exp_rd(4'd10, 32'h20, "R5 mask set");
        exp_pins(1'b1, 1'b1, "R3 fiq on");
        exp_rd(4'd8, 32'h20, "R6 fiq status");
        exp_rd(4'd9, 32'h30, "R6 raw fast view");
        bus_write(4'd11, 32'h20);
        exp_pins(1'b1, 1'b0, "R3 fiq off");
        bus_write(4'd10, 32'h20);
        // R10 status writes ignored
        bus_write(4'd0, 32'hFFFF_FFFF);
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_write(4'd8, 32'hFFFF_FFFF);
        bus_write(4'd9, 32'hFFFF_FFFF);
        exp_rd(4'd2, 32'h10, "R10 irq mask kept");
        exp_rd(4'd10, 32'h20, "R10 fiq mask kept");
        exp_rd(4'd4, 32'h0, "R10 sw latch kept");
        exp_pins(1'b1, 1'b1, "R10 pins kept");
        // R9 write-only and unused words
        exp_rd(4'd3, 32'h0, "R9 word3");
        exp_rd(4'd11, 32'h0, "R9 word11");
        exp_rd(4'd5, 32'h0, "R9 word5");
        exp_rd(4'd6, 32'h0, "R9 word6");
        exp_rd(4'd12, 32'h0, "R9 word12");
        exp_rd(4'd15, 32'h0, "R9 word15");
        // R4 clear, OR accumulation, partial clear
        bus_write(4'd3, 32'h10);
        exp_rd(4'd2, 32'h0, "R4 mask clear");
        exp_pins(1'b0, 1'b1, "R2 irq off");
        bus_write(4'd2, 32'hF000_0000);
        bus_write(4'd2, 32'h1);
        exp_rd(4'd2, 32'hF000_0001, "R4 mask OR");
        bus_write(4'd3, 32'hF000_0000);
        exp_rd(4'd2, 32'h1, "R4 partial clear");
        bus_write(4'd11, 32'hFFFF_FFFF);
        exp_rd(4'd10, 32'h0, "R5 mask clear");
        src_ext = 32'h0;
        exp_pins(1'b0, 1'b0, "R2 idle");
        // R7 software interrupt on source 0
        bus_write(4'd4, 32'h2);
        exp_rd(4'd4, 32'h0, "R7 set bit0 only");
        exp_pins(1'b0, 1'b0, "R7 no request");
        bus_write(4'd4, 32'h1);
        exp_rd(4'd4, 32'h1, "R7 latch set");
        exp_rd(4'd1, 32'h1, "R7 raw bit0");
        exp_pins(1'b1, 1'b0, "R7 request");
        bus_write(4'd5, 32'hFFFF_FFFE);
        exp_rd(4'd4, 32'h1, "R7 clr bit0 only");
        bus_write(4'd5, 32'h1);
        exp_rd(4'd4, 32'h0, "R7 latch clear");
        exp_pins(1'b0, 1'b0, "R7 request gone");
        // R8 hardware line and latch ORed
        src_ext = 32'h1;
        exp_rd(4'd4, 32'h1, "R8 line alone");
        bus_write(4'd5, 32'h1);
        exp_rd(4'd4, 32'h1, "R8 clear cannot drop line");
        exp_pins(1'b1, 1'b0, "R8 request by line");
        src_ext = 32'h0;
        exp_rd(4'd4, 32'h0, "R8 line low");
        bus_write(4'd4, 32'h1);
        src_ext = 32'h1;
        @(negedge clk);
        src_ext = 32'h0;
        exp_rd(4'd4, 32'h1, "R8 latch survives line drop");
        bus_write(4'd5, 32'h1);
        exp_rd(4'd4, 32'h0, "R8 all clear");
        // R11 cascade through source 26
        bus_write(4'd3, 32'hFFFF_FFFF);
        bus_write(4'd2, 32'h0400_0000);
        sec_write(4'd2, 32'h100);
        exp_pins(1'b0, 1'b0, "R11 idle");
        s_src = 32'h100;
        exp_pins(1'b0, 1'b0, "R11 first stage");
        exp_pins(1'b1, 1'b0, "R11 second stage");
        exp_rd(4'd0, 32'h0400_0000, "R11 status bit26");
        s_src = 32'h0;
        exp_pins(1'b1, 1'b0, "R11 fall first stage");
        exp_pins(1'b0, 1'b0, "R11 fall second stage");
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule